// File: doc/BRIEF.md
# Event-Qualified Dual-Channel PWM Generator

This block drives two pulse-width-modulated outputs from one shared 16-bit time-base counter. The counter can count up, count down, count up and then down, or hold still, and it restarts against a programmable period value. Two compare values are matched against the counter. Each output owns a small action table that says what happens to it when the counter reaches zero or when either compare value is met while counting upward. The outputs can be driven low, driven high, inverted or left as they are, so the same logic yields edge-aligned, centre-aligned and toggled waveforms.

The compare values can be taken at once or double-buffered, with a choice of when the buffered value is loaded. A newly written period never cuts the running period short. A trip input overrides both outputs with a configured safe level while it is held. Software reaches all settings through a plain write strobe and a combinational read port with eight 16-bit registers.

Top module: `pwm_dual_gen`

## Requirements
- R1: After reset both outputs are low, the counter sits at 0 in the frozen mode, and the mode register (address 0, bits [1:0]) reads 3; no output moves until a running mode is written.
- R2: In up mode (mode code 0) the period register (address 1) holds N-1, the counter steps 0..N-1 and wraps, and an output configured with drive-high on zero (bits [1:0] = 2) and drive-low on compare-A-up (bits [5:4] = 1) of its action register stays high for D ticks of every N when compare A (address 2) is D.
- R3: A compare action outranks the zero action in the same cycle, so compare value 0 keeps such an output low; a compare value above the period register never matches and keeps it high.
- R4: Action codes are 0 no change, 1 drive low, 2 drive high, 3 invert; invert on zero alone toggles the output once per period.
- R5: Output B has its own action register (address 5, output A uses address 4); bits [9:8] select the action on a compare-B (address 3) match while counting up.
- R6: In down mode (code 1) the counter runs from the period value to 0 and reloads; the zero action fires once per N ticks and compare actions never fire.
- R7: In up-down mode (code 2) the counter rises to the period value and falls back to 0, a cycle of 2(N-1) ticks; compare actions fire only on the rising half.
- R8: In frozen mode (code 3) the counter holds its value and no output changes except by the trip override.
- R9: A period write takes effect when the counter next reaches 0, so the period in progress completes at its old length.
- R10: With the shadow-enable bit clear (bit 4 for compare A, bit 6 for compare B, compare-control register at address 6), a compare write is used from the next cycle, inside the running period.
- R11: With shadow enabled, the written compare value is loaded by its load-point field (bits [1:0] for A, [3:2] for B): 0 at counter zero, 1 at counter equal to period, 2 at either, 3 never.
- R12: While the trip input is high, each output with a non-zero trip code (address 7, bits [1:0] output A, bits [3:2] output B) is forced: code 2 high, codes 1 and 3 low; code 0 leaves it to its actions, so 4'hF forces both low.
- R13: Each of the eight registers reads back at its address the value last written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 16 | Register write data |
| rdAddr | input | 3 | Register read address |
| rdData | output | 16 | Read data for rdAddr, combinational |
| tripIn | input | 1 | Trip request, level sensitive |
| pwmA | output | 1 | Output A |
| pwmB | output | 1 | Output B |

## Verification
The embedded properties assume that the counter only starts from values the block itself produced, that is, no value above the active period, and that the trip input is a clean level sampled on the clock. The stimulus holds to this by changing the period only through the register port, so the counter is never loaded from outside, and by moving the trip input and all writes half a cycle away from the active edge. Duty and toggle counts are taken over windows that span whole periods, so they do not depend on where the counter was when a window opened.

// File: rtl/pwm_gen_pkg.sv
package pwm_gen_pkg;

  localparam int REG_W    = 16;
  localparam int ADDR_W   = 3;
  localparam int NUM_REGS = 2 ** ADDR_W;
  localparam int NUM_CH   = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_PRD  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMPA = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMPB = 3'd3;
  localparam logic [ADDR_W-1:0] A_ACTA = 3'd4;
  localparam logic [ADDR_W-1:0] A_ACTB = 3'd5;
  localparam logic [ADDR_W-1:0] A_CCTL = 3'd6;
  localparam logic [ADDR_W-1:0] A_TRIP = 3'd7;

  typedef enum logic [1:0] {
    CNT_UP     = 2'd0,
    CNT_DOWN   = 2'd1,
    CNT_UPDOWN = 2'd2,
    CNT_FROZEN = 2'd3
  } cnt_mode_e;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_LOW    = 2'd1,
    ACT_HIGH   = 2'd2,
    ACT_TOGGLE = 2'd3
  } act_e;

  // Write strobes from control to datapath
  typedef struct packed {
    logic [NUM_CH-1:0] cmpWr;
    logic [REG_W-1:0]  data;
  } strobe_t;

  // Decoded configuration from control to datapath
  typedef struct packed {
    cnt_mode_e                     mode;
    logic [REG_W-1:0]              prd;
    logic [NUM_CH-1:0][REG_W-1:0]  cmpShadow;
    logic [NUM_CH-1:0]             shadowEn;
    logic [NUM_CH-1:0][1:0]        loadPt;
    act_e [NUM_CH-1:0]             zeroAct;
    act_e [NUM_CH-1:0]             cmpAAct;
    act_e [NUM_CH-1:0]             cmpBAct;
    logic [NUM_CH-1:0][1:0]        tripCode;
  } cfg_t;

endpackage

// File: rtl/pwm_gen_ctrl.sv
module pwm_gen_ctrl
  import pwm_gen_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [REG_W-1:0]  rdData,
  output cfg_t              cfg,
  output strobe_t           stb
);

  logic [REG_W-1:0] regs [NUM_REGS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
      regs[A_CTRL] <= REG_W'(CNT_FROZEN);
    end else if (wrEn) begin
      regs[wrAddr] <= wrData;
    end
  end

  assign rdData = regs[rdAddr];

  always_comb begin
    cfg.mode         = cnt_mode_e'(regs[A_CTRL][1:0]);
    cfg.prd          = regs[A_PRD];
    cfg.cmpShadow[0] = regs[A_CMPA];
    cfg.cmpShadow[1] = regs[A_CMPB];
    cfg.shadowEn[0]  = regs[A_CCTL][4];
    cfg.shadowEn[1]  = regs[A_CCTL][6];
    cfg.loadPt[0]    = regs[A_CCTL][1:0];
    cfg.loadPt[1]    = regs[A_CCTL][3:2];
    cfg.zeroAct[0]   = act_e'(regs[A_ACTA][1:0]);
    cfg.cmpAAct[0]   = act_e'(regs[A_ACTA][5:4]);
    cfg.cmpBAct[0]   = act_e'(regs[A_ACTA][9:8]);
    cfg.zeroAct[1]   = act_e'(regs[A_ACTB][1:0]);
    cfg.cmpAAct[1]   = act_e'(regs[A_ACTB][5:4]);
    cfg.cmpBAct[1]   = act_e'(regs[A_ACTB][9:8]);
    cfg.tripCode[0]  = regs[A_TRIP][1:0];
    cfg.tripCode[1]  = regs[A_TRIP][3:2];
  end

  assign stb.cmpWr[0] = wrEn && (wrAddr == A_CMPA);
  assign stb.cmpWr[1] = wrEn && (wrAddr == A_CMPB);
  assign stb.data     = wrData;

  // R13: a write shows up on the read port at the same address next cycle
  p_readback_r13: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && (rdAddr == wrAddr)) |=> (rdData == $past(wrData)));

endmodule

// File: rtl/pwm_gen_datapath.sv
module pwm_gen_datapath
  import pwm_gen_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  cfg_t              cfg,
  input  strobe_t           stb,
  input  logic              tripIn,
  output logic [NUM_CH-1:0] pwmOut
);

  logic [REG_W-1:0] cnt, cntNxt, prdAct, prdEff;
  logic             dirUp, dirNxt;
  logic             running, cntZero, prdHit, upNow, evZero, evPrd;
  logic [NUM_CH-1:0] evCmp;
  logic [REG_W-1:0] cmpAct [NUM_CH];

  always_comb begin
    cntZero = (cnt == '0);
    // a period written earlier becomes active when the counter is at zero
    prdEff  = cntZero ? cfg.prd : prdAct;
    prdHit  = (cnt == prdEff);
    running = (cfg.mode != CNT_FROZEN);
    upNow   = (cfg.mode == CNT_UP) || ((cfg.mode == CNT_UPDOWN) && dirUp);
    evZero  = running && cntZero;
    evPrd   = running && prdHit;
  end

  always_comb begin
    cntNxt = cnt;
    dirNxt = dirUp;
    case (cfg.mode)
      CNT_UP: begin
        cntNxt = (cnt >= prdEff) ? '0 : cnt + REG_W'(1);
        dirNxt = 1'b1;
      end
      CNT_DOWN: begin
        cntNxt = cntZero ? prdEff : cnt - REG_W'(1);
        dirNxt = 1'b0;
      end
      CNT_UPDOWN: begin
        if (dirUp && (cnt >= prdEff)) begin
          cntNxt = cntZero ? '0 : cnt - REG_W'(1);
          dirNxt = 1'b0;
        end else if (!dirUp && cntZero) begin
          cntNxt = (prdEff == '0) ? '0 : REG_W'(1);
          dirNxt = 1'b1;
        end else begin
          cntNxt = dirUp ? cnt + REG_W'(1) : cnt - REG_W'(1);
        end
      end
      default: begin
        cntNxt = cnt;
        dirNxt = dirUp;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt    <= '0;
      dirUp  <= 1'b1;
      prdAct <= '0;
    end else begin
      cnt    <= cntNxt;
      dirUp  <= dirNxt;
      if (cntZero) prdAct <= cfg.prd;
    end
  end

  // Compare registers: index 0 is compare A, index 1 is compare B
  for (genvar k = 0; k < NUM_CH; k++) begin : g_cmp
    logic shadowLoad;

    always_comb begin
      case (cfg.loadPt[k])
        2'd0:    shadowLoad = evZero;
        2'd1:    shadowLoad = evPrd;
        2'd2:    shadowLoad = evZero || evPrd;
        default: shadowLoad = 1'b0;
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cmpAct[k] <= '0;
      end else if (!cfg.shadowEn[k]) begin
        if (stb.cmpWr[k]) cmpAct[k] <= stb.data;
      end else if (shadowLoad) begin
        cmpAct[k] <= cfg.cmpShadow[k];
      end
    end

    assign evCmp[k] = running && upNow && (cnt == cmpAct[k]);

    // R10: an unbuffered write is in use on the next cycle
    p_immediate_r10: assert property (@(posedge clk) disable iff (!rstN)
      (stb.cmpWr[k] && !cfg.shadowEn[k]) |=> (cmpAct[k] == $past(stb.data)));

    // R11: with load point 3 the buffered value is never taken
    p_shadow_freeze_r11: assert property (@(posedge clk) disable iff (!rstN)
      (cfg.shadowEn[k] && (cfg.loadPt[k] == 2'd3)) |=> $stable(cmpAct[k]));
  end

  // Output action logic, one instance per output
  for (genvar c = 0; c < NUM_CH; c++) begin : g_out
    act_e sel;
    logic forced;
    logic outReg;

    always_comb begin
      if (evCmp[1] && (cfg.cmpBAct[c] != ACT_NONE))      sel = cfg.cmpBAct[c];
      else if (evCmp[0] && (cfg.cmpAAct[c] != ACT_NONE)) sel = cfg.cmpAAct[c];
      else if (evZero)                                   sel = cfg.zeroAct[c];
      else                                               sel = ACT_NONE;
    end

    assign forced = tripIn && (cfg.tripCode[c] != 2'd0);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        outReg <= 1'b0;
      end else if (forced) begin
        outReg <= (cfg.tripCode[c] == 2'd2);
      end else begin
        case (sel)
          ACT_LOW:    outReg <= 1'b0;
          ACT_HIGH:   outReg <= 1'b1;
          ACT_TOGGLE: outReg <= ~outReg;
          default:    outReg <= outReg;
        endcase
      end
    end

    assign pwmOut[c] = outReg;

    // R12: trip codes 1 and 3 force low, code 2 forces high
    p_trip_low_r12: assert property (@(posedge clk) disable iff (!rstN)
      (tripIn && cfg.tripCode[c][0]) |=> !pwmOut[c]);
    p_trip_high_r12: assert property (@(posedge clk) disable iff (!rstN)
      (tripIn && (cfg.tripCode[c] == 2'd2)) |=> pwmOut[c]);

    // R8: frozen without trip leaves the output alone
    p_frozen_out_r8: assert property (@(posedge clk) disable iff (!rstN)
      ((cfg.mode == CNT_FROZEN) && !tripIn) |=> $stable(pwmOut[c]));
  end

  // R2: the counter never runs past the active period
  p_cnt_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cnt != '0) |-> (cnt <= prdAct));

  // R2: in up mode the counter steps by one below the period
  p_up_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    ((cfg.mode == CNT_UP) && !cntZero && (cnt < prdAct)) |=> (cnt == $past(cnt) + REG_W'(1)));

  // R8: frozen mode holds the count
  p_frozen_cnt_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.mode == CNT_FROZEN) |=> $stable(cnt));

endmodule

// File: rtl/pwm_dual_gen.sv
module pwm_dual_gen
  import pwm_gen_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [REG_W-1:0]  wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [REG_W-1:0]  rdData,
  input  logic              tripIn,
  output logic              pwmA,
  output logic              pwmB
);

  cfg_t              cfg;
  strobe_t           stb;
  logic [NUM_CH-1:0] pwmOut;

  pwm_gen_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrAddr (wrAddr),
    .wrData (wrData),
    .rdAddr (rdAddr),
    .rdData (rdData),
    .cfg    (cfg),
    .stb    (stb)
  );

  pwm_gen_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .cfg    (cfg),
    .stb    (stb),
    .tripIn (tripIn),
    .pwmOut (pwmOut)
  );

  assign pwmA = pwmOut[0];
  assign pwmB = pwmOut[1];

endmodule

// File: tb/sim_pwm_dual_gen.sv
`timescale 1ns/1ps
module sim_pwm_dual_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [2:0]  rdAddr = '0;
  logic [15:0] rdData;
  logic        tripIn = 1'b0;
  logic        pwmA, pwmB;

  int nChecks = 0;
  int nErrors = 0;
  int cyc = 0;

  pwm_dual_gen u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .tripIn(tripIn), .pwmA(pwmA), .pwmB(pwmB)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, int actual, int expected);
    nChecks++;
    if (actual != expected) begin
      nErrors++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output int v);
    rdAddr = a;
    #1;
    v = int'(rdData);
  endtask

  task automatic settle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic countHigh(bit useB, int n, output int h);
    h = 0;
    repeat (n) begin
      @(negedge clk);
      if (useB ? pwmB : pwmA) h++;
    end
  endtask

  task automatic countChanges(bit useB, int n, output int c);
    logic p;
    c = 0;
    p = useB ? pwmB : pwmA;
    repeat (n) begin
      @(negedge clk);
      if ((useB ? pwmB : pwmA) != p) c++;
      p = useB ? pwmB : pwmA;
    end
  endtask

  task automatic syncRise();
    logic p;
    p = pwmA;
    forever begin
      @(negedge clk);
      if (!p && pwmA) break;
      p = pwmA;
    end
  endtask

  task automatic pulseWidth(output int w);
    syncRise();
    w = 0;
    while (pwmA) begin
      w++;
      @(negedge clk);
    end
  endtask

  task automatic baseUp();
    wr(3'd6, 16'h0000);
    wr(3'd1, 16'd9);
    wr(3'd0, 16'd0);
  endtask

  task automatic t_reset();
    int v, h;
    chk("R1 pwmA at reset", int'(pwmA), 0);
    chk("R1 pwmB at reset", int'(pwmB), 0);
    rd(3'd0, v);
    chk("R1 mode reads frozen", v & 3, 3);
    countHigh(1'b0, 20, h);
    chk("R1 pwmA stays low", h, 0);
  endtask

  task automatic t_readback();
    int v, h;
    wr(3'd1, 16'h1234);
    wr(3'd2, 16'h0BCD);
    wr(3'd3, 16'h2222);
    wr(3'd4, 16'h0333);
    wr(3'd5, 16'h0303);
    wr(3'd7, 16'h0005);
    wr(3'd6, 16'h0055);
    rd(3'd1, v); chk("R13 period readback", v, 16'h1234);
    rd(3'd2, v); chk("R13 compare A readback", v, 16'h0BCD);
    rd(3'd3, v); chk("R13 compare B readback", v, 16'h2222);
    rd(3'd4, v); chk("R13 action A readback", v, 16'h0333);
    rd(3'd5, v); chk("R13 action B readback", v, 16'h0303);
    rd(3'd6, v); chk("R13 compare control readback", v, 16'h0055);
    rd(3'd7, v); chk("R13 trip readback", v, 16'h0005);
    countHigh(1'b0, 10, h);
    chk("R8 frozen, toggle actions set, A unchanged", h, 0);
    wr(3'd6, 16'h0000);
    wr(3'd1, 16'd0);
    wr(3'd2, 16'd0);
    wr(3'd3, 16'd0);
    wr(3'd4, 16'd0);
    wr(3'd5, 16'd0);
    wr(3'd7, 16'd0);
  endtask

  task automatic t_up();
    int h, c;
    wr(3'd2, 16'd3);
    wr(3'd4, 16'h0012);
    baseUp();
    settle(30);
    countHigh(1'b0, 100, h);
    chk("R2 up mode duty 3 of 10", h, 30);
    countChanges(1'b0, 100, c);
    chk("R2 up mode period 10 ticks", c, 20);
  endtask

  task automatic t_extremes();
    int h;
    wr(3'd2, 16'd0);
    settle(20);
    countHigh(1'b0, 100, h);
    chk("R3 compare 0 keeps output low", h, 0);
    wr(3'd2, 16'd10);
    settle(20);
    countHigh(1'b0, 100, h);
    chk("R3 compare above period keeps output high", h, 100);
  endtask

  task automatic t_chanB();
    int h, c;
    wr(3'd3, 16'd7);
    wr(3'd5, 16'h0102);
    settle(20);
    countHigh(1'b1, 100, h);
    chk("R5 output B duty 7 of 10", h, 70);
    wr(3'd5, 16'h0003);
    settle(20);
    countChanges(1'b1, 100, c);
    chk("R4 toggle on zero once per period", c, 10);
  endtask

  task automatic t_down();
    int h, c;
    wr(3'd2, 16'd3);
    wr(3'd4, 16'h0013);
    wr(3'd0, 16'd1);
    settle(30);
    countChanges(1'b0, 100, c);
    chk("R6 down mode zero toggles only", c, 10);
    countHigh(1'b0, 100, h);
    chk("R6 down mode compare ignored", h, 50);
  endtask

  task automatic t_updown();
    int h, c;
    wr(3'd4, 16'h0030);
    wr(3'd0, 16'd2);
    settle(40);
    countChanges(1'b0, 180, c);
    chk("R7 up-down compare fires on rising half only", c, 10);
    wr(3'd4, 16'h0012);
    settle(40);
    countHigh(1'b0, 180, h);
    chk("R7 up-down duty 3 of 18", h, 30);
  endtask

  task automatic t_frozen();
    int c;
    wr(3'd0, 16'd0);
    wr(3'd4, 16'h0003);
    settle(20);
    countChanges(1'b0, 100, c);
    chk("R8 running toggle reference", c, 10);
    wr(3'd0, 16'd3);
    settle(2);
    countChanges(1'b0, 50, c);
    chk("R8 frozen mode holds output", c, 0);
  endtask

  task automatic t_period();
    int t0, t1, t2;
    wr(3'd2, 16'd5);
    wr(3'd4, 16'h0012);
    wr(3'd0, 16'd0);
    settle(20);
    syncRise(); t0 = cyc;
    settle(3);
    wr(3'd1, 16'd19);
    syncRise(); t1 = cyc;
    syncRise(); t2 = cyc;
    chk("R9 running period finishes at old length", t1 - t0, 10);
    chk("R9 new period after wrap", t2 - t1, 20);
    wr(3'd1, 16'd9);
    settle(40);
  endtask

  task automatic t_immediate();
    int w;
    wr(3'd6, 16'h0000);
    wr(3'd2, 16'd8);
    settle(20);
    syncRise();
    wr(3'd2, 16'd3);
    w = 2;
    while (pwmA) begin
      w++;
      @(negedge clk);
    end
    w = w - 1;
    chk("R10 immediate compare in running period", w, 3);
  endtask

  task automatic shadowCase(int lp, int e1, int e2);
    int p1, p2;
    wr(3'd6, 16'h0000);
    wr(3'd2, 16'd8);
    settle(20);
    wr(3'd6, 16'(16'h0010 | lp));
    syncRise();
    settle(8);
    wr(3'd2, 16'd3);
    pulseWidth(p1);
    pulseWidth(p2);
    chk($sformatf("R11 load point %0d first pulse", lp), p1, e1);
    chk($sformatf("R11 load point %0d second pulse", lp), p2, e2);
  endtask

  task automatic t_shadow();
    shadowCase(0, 3, 3);
    shadowCase(1, 8, 3);
    shadowCase(2, 3, 3);
    shadowCase(3, 8, 8);
    wr(3'd6, 16'h0000);
  endtask

  task automatic t_trip();
    int h;
    wr(3'd2, 16'd3);
    wr(3'd4, 16'h0012);
    wr(3'd3, 16'd7);
    wr(3'd5, 16'h0102);
    wr(3'd7, 16'h000F);
    settle(20);
    tripIn = 1'b1;
    settle(2);
    countHigh(1'b0, 50, h); chk("R12 trip 4'hF forces A low", h, 0);
    countHigh(1'b1, 50, h); chk("R12 trip 4'hF forces B low", h, 0);
    wr(3'd7, 16'h0006);
    settle(2);
    countHigh(1'b0, 50, h); chk("R12 trip code 2 forces A high", h, 50);
    countHigh(1'b1, 50, h); chk("R12 trip code 1 forces B low", h, 0);
    wr(3'd7, 16'h0000);
    settle(20);
    countHigh(1'b0, 100, h); chk("R12 trip code 0 leaves A to actions", h, 30);
    countHigh(1'b1, 100, h); chk("R12 trip code 0 leaves B to actions", h, 70);
    tripIn = 1'b0;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_up();
    t_extremes();
    t_chanB();
    t_down();
    t_updown();
    t_frozen();
    t_period();
    t_immediate();
    t_shadow();
    t_trip();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    #1000000;
    nChecks++;
    nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule